// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral guards a system against software that stops making progress. Software places a timeout in the control register, counted in half-second units, and then sets the enable bit. From that point the countdown can never be turned off again. To keep the system alive, software must refresh the counter by writing two key words to the service register in the right order: first 0x5555, then 0xAAAA. If the count runs out, the block raises a system reset request, provided the reset-enable bit allows it. It also sets a timeout flag in a status register. That register sits on its own power-on reset, so the flag is still there after the system reset it caused.

The counter is driven by a slow timebase. Each pulse on `lf_tick` is one period of the roughly 32 kHz clock, and `TICKS_PER_HALF` pulses make up one half second. The block has three further functions:
- a software-triggered reset request;
- an option that freezes the countdown while the chip is in low-power mode;
- a power-down counter that runs on its own from reset and gives one low pulse on an active-low interrupt line, unless software turns it off first.

The register port is a plain single-cycle write strobe with a combinational read. It has no valid/ready handshake, because no data streams through this block.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n` and `por_n` are released, the registers read as follows: control (0x0) reads 0x0010, service (0x2) reads 0x0000, status (0x4) reads 0x0000 and misc (0x8) reads 0x0001. `wdog_rst_o` and `sw_rst_o` are low and `wdog_int_n` is high.
- R2: Control bits 15:8 hold the timeout field N, bit 3 is reset-enable, bit 2 is enable, bit 4 is an active-low software-reset request and bit 0 is low-power suspend. Once enabled with reset-enable set, `wdog_rst_o` rises after exactly (N+1)*TICKS_PER_HALF `lf_tick` pulses, counted from the cycle after the enabling write, and not one pulse earlier.
- R3: Writing 0x5555 to the service register (0x2) and then 0xAAAA reloads the counter from the timeout field and restarts the count.
- R4: Any other service write returns the key checker to idle without a refresh. This covers a wrong word, 0xAAAA written first, and a foreign word between the two keys. A repeated 0x5555 keeps the checker armed.
- R5: The enable bit is sticky. A control write with bit 2 = 0 does not clear it, and the countdown keeps running.
- R6: The suspend bit (bit 0) is sticky once set. While it is set and `low_power` is high, the countdown holds its value.
- R7: Status bit 1 is set on a timeout. It survives `rst_n` and is cleared only by `por_n`.
- R8: A timeout while reset-enable is 0 keeps `wdog_rst_o` low but still sets status bit 1.
- R9: A control write with bit 4 = 0 raises `sw_rst_o` from the next cycle until the next `lf_tick`. Further such writes, or writes with bit 4 = 1, inside that period do not cancel it. The write also sets status bit 0.
- R10: The timeout field may be rewritten while the counter runs. The new value is used only at the next reload.
- R11: From reset, the power-down counter counts PDC_TICKS `lf_tick` pulses and then drives `wdog_int_n` low for exactly one clock. Writing misc (0x8) with bit 0 = 0 beforehand disables it permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset; clears everything except status |
| por_n | input | 1 | Active-low power-on reset; clears status |
| lf_tick | input | 1 | One-cycle pulse per low-frequency timebase period |
| low_power | input | 1 | High while the chip is in low-power mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| wdog_rst_o | output | 1 | Reset request on timeout |
| sw_rst_o | output | 1 | Software reset request |
| wdog_int_n | output | 1 | Active-low power-down counter pulse |

## Verification
The bench walks a set of three-word service sequences through a counter that is nearly expired. It includes sequences that are misordered, interrupted or start with a double arm. A checker that refreshed on 0xAAAA alone, or that failed to drop back to idle on a foreign word, would survive where the bench expects a reset, or the reverse. Expiry is checked one tick before and exactly at (N+1) half periods, so an off-by-one reload shows at once. Other corner cases are probed at the pins and through read-back:
- a write of 0 to enable and to suspend;
- a field rewrite in mid-count;
- several software-reset writes in one slow period;
- the status bit across a system reset.

A design that cleared those bits, applied the new field at once, or let the software request drop early would fail there.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] OFS_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] OFS_SVC  = 4'h2;
  localparam logic [REG_AW-1:0] OFS_STAT = 4'h4;
  localparam logic [REG_AW-1:0] OFS_MISC = 4'h8;

  localparam logic [REG_DW-1:0] KEY_ARM  = 16'h5555;
  localparam logic [REG_DW-1:0] KEY_FIRE = 16'hAAAA;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  // control register layout, MSB first
  typedef struct packed {
    logic [7:0] tmo;
    logic [2:0] rsv_hi;
    logic       swr_n;
    logic       rst_en;
    logic       en;
    logic       rsv_lo;
    logic       susp;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              lf_tick,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              expire_p,
  output ctrl_t             ctrl,
  output logic              start_p,
  output logic              svc_wr,
  output logic              pd_en,
  output logic              stat_tout,
  output logic              stat_sw,
  output logic [REG_DW-1:0] reg_rdata
);
  ctrl_t wd;
  logic  ctrl_wr, misc_wr, swreq_p, en_d;

  assign wd      = ctrl_t'(reg_wdata);
  assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
  assign misc_wr = reg_wr && (reg_addr == OFS_MISC);
  assign svc_wr  = reg_wr && (reg_addr == OFS_SVC);
  assign swreq_p = ctrl_wr && !wd.swr_n;
  assign start_p = ctrl.en && !en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      ctrl.swr_n <= 1'b1;
      en_d       <= 1'b0;
      pd_en      <= 1'b1;
    end else begin
      en_d <= ctrl.en;
      if (ctrl_wr) begin
        ctrl.tmo    <= wd.tmo;
        ctrl.rst_en <= wd.rst_en;
        ctrl.en     <= ctrl.en | wd.en;
        ctrl.susp   <= ctrl.susp | wd.susp;
      end
      if (swreq_p)      ctrl.swr_n <= 1'b0;
      else if (lf_tick) ctrl.swr_n <= 1'b1;
      if (misc_wr) pd_en <= pd_en & reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat_tout <= 1'b0;
      stat_sw   <= 1'b0;
    end else begin
      if (expire_p) stat_tout <= 1'b1;
      if (swreq_p)  stat_sw   <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL: reg_rdata = REG_DW'(ctrl);
      OFS_STAT: reg_rdata = {{(REG_DW-2){1'b0}}, stat_tout, stat_sw};
      OFS_MISC: reg_rdata = {{(REG_DW-1){1'b0}}, pd_en};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_keycheck.sv
module wdt_keycheck
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [REG_DW-1:0] wdata,
  output logic              refresh_p
);
  key_state_e st, st_nx;

  always_comb begin
    st_nx     = st;
    refresh_p = 1'b0;
    if (svc_wr) begin
      if (wdata == KEY_ARM) begin
        st_nx = KS_ARMED;
      end else begin
        st_nx     = KS_IDLE;
        refresh_p = (st == KS_ARMED) && (wdata == KEY_FIRE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KS_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int TMO_W          = 8,
  parameter int TICKS_PER_HALF = 16384,
  localparam int PRE_W         = (TICKS_PER_HALF > 1) ? $clog2(TICKS_PER_HALF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             tick,
  input  logic             reload,
  input  logic [TMO_W-1:0] load_val,
  output logic [TMO_W-1:0] hp_cnt,
  output logic             expired,
  output logic             expire_p
);
  logic [PRE_W-1:0] pre;
  logic             step, half_done;

  assign step      = run && !expired && tick && !hold && !reload;
  assign half_done = (pre == PRE_W'(TICKS_PER_HALF - 1));
  assign expire_p  = step && half_done && (hp_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      hp_cnt  <= '0;
      expired <= 1'b0;
    end else if (reload) begin
      pre    <= '0;
      hp_cnt <= load_val;
    end else if (step) begin
      if (half_done) begin
        pre <= '0;
        if (hp_cnt == '0) expired <= 1'b1;
        else              hp_cnt  <= hp_cnt - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_pdc.sv
module wdt_pdc #(
  parameter int PDC_TICKS = 524288,
  localparam int PDC_W    = (PDC_TICKS > 1) ? $clog2(PDC_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_en,
  input  logic tick,
  output logic int_n
);
  logic [PDC_W-1:0] cnt;
  logic             done, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (pd_en && !done && tick) begin
        if (cnt == PDC_W'(PDC_TICKS - 1)) begin
          done <= 1'b1;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign int_n = !fire;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int TICKS_PER_HALF = 16384,
  parameter int PDC_TICKS      = 524288
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        lf_tick,
  input  logic        low_power,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wdog_rst_o,
  output logic        sw_rst_o,
  output logic        wdog_int_n
);
  import wdt_pkg::*;
  localparam int TMO_W = 8;

  ctrl_t            ctrl;
  logic             start_p, svc_wr, pd_en, stat_tout, stat_sw;
  logic             refresh_p, reload, expired, expire_p;
  logic [TMO_W-1:0] hp_cnt;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .lf_tick(lf_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .expire_p(expire_p), .ctrl(ctrl), .start_p(start_p), .svc_wr(svc_wr),
    .pd_en(pd_en), .stat_tout(stat_tout), .stat_sw(stat_sw),
    .reg_rdata(reg_rdata)
  );

  wdt_keycheck u_key (
    .clk(clk), .rst_n(rst_n), .svc_wr(svc_wr), .wdata(reg_wdata),
    .refresh_p(refresh_p)
  );

  assign reload = (refresh_p && ctrl.en) || start_p;

  wdt_countdown #(.TMO_W(TMO_W), .TICKS_PER_HALF(TICKS_PER_HALF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.en), .hold(ctrl.susp && low_power),
    .tick(lf_tick), .reload(reload), .load_val(ctrl.tmo),
    .hp_cnt(hp_cnt), .expired(expired), .expire_p(expire_p)
  );

  wdt_pdc #(.PDC_TICKS(PDC_TICKS)) u_pdc (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .tick(lf_tick), .int_n(wdog_int_n)
  );

  assign wdog_rst_o = expired && ctrl.rst_en;
  assign sw_rst_o   = !ctrl.swr_n;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             lf_tick,
  input logic             low_power,
  input logic             en,
  input logic             susp,
  input logic             rst_en,
  input logic             reload,
  input logic             expired,
  input logic             stat_tout,
  input logic [TMO_W-1:0] hp_cnt,
  input logic             wdog_rst_o,
  input logic             sw_rst_o,
  input logic             wdog_int_n
);
  // R5
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  // R6
  susp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> susp);
  // R6
  lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && low_power && !reload) |=> $stable(hp_cnt));
  // R8
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> rst_en);
  // R7
  tout_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    expired |-> stat_tout);
  // R9
  swreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst_o && !lf_tick) |=> sw_rst_o);
  // R11
  int_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_int_n |=> wdog_int_n);
endmodule

bind keyed_wdt keyed_wdt_chk #(.TMO_W(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_n(por_n), .lf_tick(lf_tick),
  .low_power(low_power), .en(ctrl.en), .susp(ctrl.susp),
  .rst_en(ctrl.rst_en), .reload(reload), .expired(expired),
  .stat_tout(stat_tout), .hp_cnt(hp_cnt), .wdog_rst_o(wdog_rst_o),
  .sw_rst_o(sw_rst_o), .wdog_int_n(wdog_int_n)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int TPH        = 4;
  localparam int PDC        = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0, lf_tick = 1'b0, low_power = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wdog_rst_o, sw_rst_o, wdog_int_n;

  int n_chk = 0, n_fail = 0, int_low = 0;
  logic cnt_clr = 1'b0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt #(.TICKS_PER_HALF(TPH), .PDC_TICKS(PDC)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .lf_tick(lf_tick),
    .low_power(low_power), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdog_rst_o(wdog_rst_o),
    .sw_rst_o(sw_rst_o), .wdog_int_n(wdog_int_n)
  );

  always @(negedge clk) begin
    if (cnt_clr)          int_low <= 0;
    else if (!wdog_int_n) int_low <= int_low + 1;
  end

  // {word1, word2, word3, refresh expected}
  localparam logic [48:0] VEC [8] = '{
    {16'h5555, 16'hAAAA, 16'h0000, 1'b1},
    {16'hAAAA, 16'h5555, 16'h0000, 1'b0},
    {16'h5555, 16'h1234, 16'hAAAA, 1'b0},
    {16'h5555, 16'h5555, 16'hAAAA, 1'b1},
    {16'h0000, 16'h5555, 16'hAAAA, 1'b1},
    {16'hAAAA, 16'hAAAA, 16'hAAAA, 1'b0},
    {16'h5555, 16'h0000, 16'h0000, 1'b0},
    {16'h1234, 16'h5555, 16'hAAAA, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    cnt_clr = 1'b1;
    low_power = 1'b0;
    idle(2);
    rst_n = 1'b1;
    por_n = 1'b1;
    cnt_clr = 1'b0;
    idle(1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      lf_tick = 1'b1;
      @(negedge clk);
      lf_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    logic [15:0] r;
    do_reset(1'b1);
    // R1 reset state
    rd(4'h0, r); chk("R1 ctrl", r, 16'h0010);
    rd(4'h2, r); chk("R1 svc", r, 16'h0000);
    rd(4'h4, r); chk("R1 stat", r, 16'h0000);
    rd(4'h8, r); chk("R1 misc", r, 16'h0001);
    chk("R1 outs", {13'b0, wdog_rst_o, sw_rst_o, wdog_int_n}, 16'h0001);

    // R3 R4 key sequence table, timeout N=1 -> 8 ticks
    for (int i = 0; i < 8; i++) begin
      do_reset(1'b0);
      wr(4'h0, 16'h011C);
      idle(2);
      ticks(6);
      wr(4'h2, VEC[i][48:33]);
      wr(4'h2, VEC[i][32:17]);
      wr(4'h2, VEC[i][16:1]);
      ticks(3);
      chk(VEC[i][0] ? "R3 refresh" : "R4 no refresh", {15'b0, wdog_rst_o}, {15'b0, !VEC[i][0]});
      if (VEC[i][0]) begin
        ticks(5);
        chk("R3 reload length", {15'b0, wdog_rst_o}, 16'h0001);
      end
    end

    // R2 exact expiry, N=2 -> 12 ticks
    do_reset(1'b0);
    wr(4'h0, 16'h021C);
    idle(2);
    ticks(11);
    chk("R2 before expiry", {15'b0, wdog_rst_o}, 16'h0000);
    ticks(1);
    chk("R2 at expiry", {15'b0, wdog_rst_o}, 16'h0001);
    // R7 status survives system reset, cleared by power-on reset
    do_reset(1'b0);
    chk("R7 rst cleared", {15'b0, wdog_rst_o}, 16'h0000);
    rd(4'h4, r); chk("R7 stat kept", r, 16'h0002);
    do_reset(1'b1);
    rd(4'h4, r); chk("R7 stat por", r, 16'h0000);

    // R8 timeout without reset-enable
    wr(4'h0, 16'h0014);
    idle(2);
    ticks(4);
    chk("R8 gated", {15'b0, wdog_rst_o}, 16'h0000);
    rd(4'h4, r); chk("R8 stat", r, 16'h0002);

    // R5 enable cannot be cleared
    do_reset(1'b1);
    wr(4'h0, 16'h001C);
    wr(4'h0, 16'h0018);
    rd(4'h0, r); chk("R5 en sticky", r, 16'h001C);
    ticks(4);
    chk("R5 still runs", {15'b0, wdog_rst_o}, 16'h0001);

    // R6 suspend sticky and hold in low power
    do_reset(1'b0);
    wr(4'h0, 16'h001D);
    wr(4'h0, 16'h001C);
    rd(4'h0, r); chk("R6 susp sticky", r, 16'h001D);
    low_power = 1'b1;
    ticks(10);
    chk("R6 held", {15'b0, wdog_rst_o}, 16'h0000);
    low_power = 1'b0;
    ticks(3);
    chk("R6 resumed early", {15'b0, wdog_rst_o}, 16'h0000);
    ticks(1);
    chk("R6 resumed expiry", {15'b0, wdog_rst_o}, 16'h0001);

    // R9 software reset request
    do_reset(1'b1);
    wr(4'h0, 16'h0000);
    chk("R9 asserted", {15'b0, sw_rst_o}, 16'h0001);
    rd(4'h0, r); chk("R9 ctrl bit4", r, 16'h0000);
    wr(4'h0, 16'h0000);
    wr(4'h0, 16'h0010);
    idle(3);
    chk("R9 not cancelled", {15'b0, sw_rst_o}, 16'h0001);
    ticks(1);
    chk("R9 released at tick", {15'b0, sw_rst_o}, 16'h0000);
    rd(4'h4, r); chk("R9 stat", r, 16'h0001);

    // R10 field rewrite applies at next reload
    do_reset(1'b1);
    wr(4'h0, 16'h031C);
    idle(2);
    ticks(4);
    wr(4'h0, 16'h001C);
    ticks(4);
    chk("R10 old field kept", {15'b0, wdog_rst_o}, 16'h0000);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    ticks(3);
    chk("R10 new field early", {15'b0, wdog_rst_o}, 16'h0000);
    ticks(1);
    chk("R10 new field expiry", {15'b0, wdog_rst_o}, 16'h0001);

    // R11 power-down counter pulse
    do_reset(1'b1);
    ticks(PDC - 1);
    chk("R11 no early pulse", int_low[15:0], 16'h0000);
    ticks(1);
    idle(3);
    chk("R11 one pulse", int_low[15:0], 16'h0001);
    do_reset(1'b1);
    wr(4'h8, 16'h0000);
    rd(4'h8, r); chk("R11 misc off", r, 16'h0000);
    ticks(PDC + 5);
    chk("R11 disabled", int_low[15:0], 16'h0000);

    finish_sim();
  end
endmodule